// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register File

This block is the host-visible register file for a two-channel disk bus-master DMA controller. It sits behind a 16-byte I/O window, and each channel owns an 8-byte slice of that window. In each slice the host finds a command byte, a status byte and a 32-bit descriptor-table base address. The DMA engine itself, descriptor fetching and the disk bus are outside this block. The block only holds the control state, hands it to the engine and takes flag updates back from the engine.

The host bus carries one request per cycle: address, write flag, access size and write data. A read answers one cycle later with `rd_valid`, and the data is right-aligned in `rd_data`. Only byte-sized accesses reach the registers. A wider read returns all ones across its width, and a wider write is dropped.

The status byte holds three kinds of bit in one byte:
- a live "active" bit that follows the engine,
- two plain read/write configuration bits,
- two sticky flags (interrupt and error) that the engine sets and the host clears by writing 1.

Channel 0 is the primary channel and channel 1 the secondary. Each channel's interrupt flag is brought out to drive that channel's legacy interrupt line.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, every command, status and base-address byte reads as 0x00 (with the engine active inputs low), and no start pulse, run, direction or interrupt output is asserted.
- R2: Bit 3 of the byte address selects the channel. Within a channel, offset 0 is command, offset 2 is status, offsets 4..7 are base-address bytes 0..3, and offsets 1 and 3 read as 0xFF. Every read request gets `rd_valid` on the following cycle.
- R3: A read with `bus_size` not 0 (0 = byte, 1 = 16-bit, 2 or 3 = 32-bit) returns 0x0000FFFF for size 1 and 0xFFFFFFFF for sizes 2 and 3, whatever the address.
- R4: A write with `bus_size` not 0 changes no register anywhere in the window.
- R5: A byte write to status loads status bits 6:5 from write data bits 6:5.
- R6: In a status write, a 1 in data bit 2 clears the interrupt flag (status bit 2) and a 1 in data bit 1 clears the error flag (status bit 1). A 0 in either bit leaves that flag as it is.
- R7: Status bit 0 always reads the channel's `eng_active` input, and status writes have no effect on it.
- R8: Status bits 7, 4 and 3 always read 0.
- R9: A `set_irq` or `set_err` strobe sets status bit 2 or bit 1 respectively. When a strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: A byte write at offset 4+k loads byte k of the channel's base address, with bits 1:0 always forced to 0. The value is driven on `prd_base`, 32 bits per channel, with channel 0 in the low half.
- R11: A command write latches data bit 0 (run) and bit 3 (direction). Reads return only these two bits, with all other command bits 0, and the bits are driven on `cmd_run` and `cmd_dir`.
- R12: A command write that changes run from 0 to 1 gives a one-cycle `dma_start` pulse for that channel in the cycle after the write. Writing run=1 while run is already 1 gives no pulse.
- R13: `irq_line[n]` equals channel n's interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Host access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the window |
| bus_size | input | 2 | 0 byte, 1 half, 2/3 word |
| bus_wdata | input | 32 | Write data, byte in bits 7:0 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| eng_active | input | 2 | Engine busy per channel |
| set_irq | input | 2 | Engine interrupt set strobe per channel |
| set_err | input | 2 | Engine error set strobe per channel |
| dma_start | output | 2 | One-cycle start pulse per channel |
| cmd_run | output | 2 | Latched run bit per channel |
| cmd_dir | output | 2 | Latched direction bit per channel |
| irq_line | output | 2 | Interrupt flag per channel |
| prd_base | output | 64 | Base addresses, channel 0 in 31:0 |

## Verification
The bench targets the mixed status byte. It writes all ones to catch a design that lets the active bit or the unused bits be written. It writes 0 to the sticky flags to catch a design that clears them on any write. It drives a set strobe together with a clearing write to expose a design where the clear wins. It repeats run=1 to expose a start pulse that fires on level instead of on the 0-to-1 change. It issues wide reads and writes to catch decoding that ignores the access size. It writes base-address bytes out of order to expose a wrong byte lane and a missing alignment mask.

// File: rtl/bmdma_regfile.sv
module bmdma_regfile #(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [NCH-1:0]    eng_active,
  input  logic [NCH-1:0]    set_irq,
  input  logic [NCH-1:0]    set_err,
  output logic [NCH-1:0]    dma_start,
  output logic [NCH-1:0]    cmd_run,
  output logic [NCH-1:0]    cmd_dir,
  output logic [NCH-1:0]    irq_line,
  output logic [NCH*32-1:0] prd_base
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] st_irq, st_err;
  logic [1:0]     st_cfg [NCH];
  logic [31:0]    base   [NCH];

  logic [CW-1:0] ch;
  logic [2:0]    off;
  logic          byte_acc, wr_hit;
  logic [7:0]    wb;

  assign ch       = CW'(bus_addr[AW-1:3]);
  assign off      = bus_addr[2:0];
  assign byte_acc = (bus_size == 2'd0);
  assign wr_hit   = bus_req && bus_wr && byte_acc;
  assign wb       = bus_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_run   <= '0;
      cmd_dir   <= '0;
      dma_start <= '0;
      st_irq    <= '0;
      st_err    <= '0;
      for (int i = 0; i < NCH; i++) begin
        st_cfg[i] <= '0;
        base[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        logic sel, wst;
        sel = wr_hit && (ch == CW'(i));
        wst = sel && (off == 3'd2);
        dma_start[i] <= sel && (off == 3'd0) && wb[0] && !cmd_run[i];
        if (sel && off == 3'd0) begin
          cmd_run[i] <= wb[0];
          cmd_dir[i] <= wb[3];
        end
        if (wst) st_cfg[i] <= wb[6:5];
        st_irq[i] <= set_irq[i] | (st_irq[i] & ~(wst & wb[2]));
        st_err[i] <= set_err[i] | (st_err[i] & ~(wst & wb[1]));
        if (sel && off[2]) begin
          case (off[1:0])
            2'd0:    base[i][7:0]   <= {wb[7:2], 2'b00};
            2'd1:    base[i][15:8]  <= wb;
            2'd2:    base[i][23:16] <= wb;
            default: base[i][31:24] <= wb;
          endcase
        end
      end
    end
  end

  logic [7:0]  sel_byte;
  logic [31:0] rd_next;

  always_comb begin
    sel_byte = 8'hFF;
    for (int i = 0; i < NCH; i++) begin
      if (ch == CW'(i)) begin
        case (off)
          3'd0: sel_byte = {4'b0, cmd_dir[i], 2'b0, cmd_run[i]};
          3'd2: sel_byte = {1'b0, st_cfg[i], 2'b0, st_irq[i], st_err[i], eng_active[i]};
          3'd4: sel_byte = base[i][7:0];
          3'd5: sel_byte = base[i][15:8];
          3'd6: sel_byte = base[i][23:16];
          3'd7: sel_byte = base[i][31:24];
          default: sel_byte = 8'hFF;
        endcase
      end
    end
    case (bus_size)
      2'd0:    rd_next = {24'b0, sel_byte};
      2'd1:    rd_next = 32'h0000_FFFF;
      default: rd_next = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_req && !bus_wr;
      if (bus_req && !bus_wr) rd_data <= rd_next;
    end
  end

  assign irq_line = st_irq;

  for (genvar g = 0; g < NCH; g++) begin : g_base
    assign prd_base[g*32 +: 32] = base[g];
  end
endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk #(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [1:0]        bus_size,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [NCH-1:0]    set_irq,
  input logic [NCH-1:0]    dma_start,
  input logic [NCH-1:0]    cmd_run,
  input logic [NCH-1:0]    irq_line,
  input logic [NCH*32-1:0] prd_base
);
  p_read_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_wr |=> rd_valid);

  p_wide_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_wr && bus_size[1] |=> rd_data == 32'hFFFF_FFFF);

  p_wide_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_wr && bus_size != 2'd0 |=> $stable(cmd_run) && $stable(prd_base));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_irq[g] |=> irq_line[g]);

    p_base_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
      prd_base[g*32 +: 2] == 2'b00);

    p_start_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start[g] |=> !dma_start[g]);

    p_start_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start[g] |-> cmd_run[g] && !$past(cmd_run[g]));
  end
endmodule

bind bmdma_regfile bmdma_regfile_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_size(bus_size), .rd_valid(rd_valid), .rd_data(rd_data),
  .set_irq(set_irq), .dma_start(dma_start), .cmd_run(cmd_run),
  .irq_line(irq_line), .prd_base(prd_base)
);

// File: tb/bmdma_regfile_bench.sv
module bmdma_regfile_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_req = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [1:0]  bus_size = 0;
  logic [31:0] bus_wdata = 0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  eng_active = 0, set_irq = 0, set_err = 0;
  logic [1:0]  dma_start, cmd_run, cmd_dir, irq_line;
  logic [63:0] prd_base;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  bmdma_regfile u_bmdma_regfile (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .eng_active(eng_active),
    .set_irq(set_irq), .set_err(set_err), .dma_start(dma_start),
    .cmd_run(cmd_run), .cmd_dir(cmd_dir), .irq_line(irq_line),
    .prd_base(prd_base)
  );

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected read data act=%h exp=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s read act=%h exp=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic acc(input logic wr, input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    bus_req = 1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    acc(1, a, 2'd0, {24'b0, d});
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    acc(0, a, sz, 0);
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] e, input string t);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", t, act, e);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({dma_start, cmd_run, cmd_dir, irq_line}, 0, "R1 outputs");
    rd(4'h0, 0, 32'h00, "R1 cmd0");
    rd(4'h2, 0, 32'h00, "R1 st0");
    rd(4'h8, 0, 32'h00, "R1 cmd1");
    rd(4'hA, 0, 32'h00, "R1 st1");
    for (int k = 4; k < 8; k++) rd(4'(k), 0, 32'h00, "R1 base0");
    // R2 holes
    rd(4'h1, 0, 32'hFF, "R2 off1");
    rd(4'h3, 0, 32'hFF, "R2 off3");
    rd(4'hB, 0, 32'hFF, "R2 ch1 off3");
    // R11 / R12 command
    wr8(4'h0, 8'hFF);
    chk(dma_start, 2'b01, "R12 pulse");
    chk({cmd_run, cmd_dir}, 4'b0101, "R11 latch");
    @(negedge clk);
    chk(dma_start, 2'b00, "R12 single cycle");
    rd(4'h0, 0, 32'h09, "R11 readback");
    wr8(4'h0, 8'h01);
    chk(dma_start, 2'b00, "R12 no repeat");
    wr8(4'h0, 8'h00);
    wr8(4'h0, 8'h01);
    chk(dma_start, 2'b01, "R12 second pulse");
    wr8(4'h8, 8'h08);
    chk({dma_start, cmd_run, cmd_dir}, 6'b000110, "R11 ch1 dir only");
    rd(4'h8, 0, 32'h08, "R11 ch1 read");
    rd(4'h0, 0, 32'h01, "R2 ch0 separate");
    // R5 R7 R8 status writes
    wr8(4'h2, 8'hFF);
    rd(4'h2, 0, 32'h60, "R8 status all ones");
    wr8(4'h2, 8'h20);
    rd(4'h2, 0, 32'h20, "R5 cfg bits");
    // R9 set strobes, R13
    set_irq = 2'b01; @(negedge clk); set_irq = 0;
    chk(irq_line, 2'b01, "R13 irq line");
    rd(4'h2, 0, 32'h24, "R9 irq set");
    set_err = 2'b10; @(negedge clk); set_err = 0;
    rd(4'hA, 0, 32'h02, "R9 err set ch1");
    // R6 write one to clear
    wr8(4'h2, 8'h20);
    rd(4'h2, 0, 32'h24, "R6 zero keeps");
    wr8(4'h2, 8'h24);
    chk(irq_line, 2'b00, "R13 irq cleared");
    rd(4'h2, 0, 32'h20, "R6 one clears");
    wr8(4'hA, 8'h02);
    rd(4'hA, 0, 32'h00, "R6 err clears");
    // R9 set beats clear
    set_irq = 2'b01;
    wr8(4'h2, 8'h24);
    set_irq = 0;
    rd(4'h2, 0, 32'h24, "R9 set wins");
    wr8(4'h2, 8'h24);
    rd(4'h2, 0, 32'h20, "R6 clear after");
    // R7 active bit
    eng_active = 2'b01;
    rd(4'h2, 0, 32'h21, "R7 active live");
    wr8(4'h2, 8'h00);
    rd(4'h2, 0, 32'h01, "R7 write no effect");
    eng_active = 0;
    rd(4'h2, 0, 32'h00, "R7 follows input");
    // R10 base address bytes
    wr8(4'hC, 8'hFF);
    chk(prd_base, 64'h0000_00FC_0000_0000, "R10 align");
    wr8(4'hF, 8'hA5);
    wr8(4'hD, 8'h12);
    wr8(4'hE, 8'h34);
    chk(prd_base, 64'hA534_12FC_0000_0000, "R10 bytes");
    rd(4'hC, 0, 32'hFC, "R10 read low");
    rd(4'hF, 0, 32'hA5, "R10 read high");
    // R3 wide reads
    rd(4'h0, 1, 32'h0000_FFFF, "R3 half");
    rd(4'h2, 2, 32'hFFFF_FFFF, "R3 word");
    rd(4'hC, 3, 32'hFFFF_FFFF, "R3 word base");
    // R4 wide writes dropped
    acc(1, 4'h0, 2, 32'h0);
    chk(cmd_run, 2'b01, "R4 cmd kept");
    set_irq = 2'b01; @(negedge clk); set_irq = 0;
    acc(1, 4'h2, 1, 32'hFF);
    chk(irq_line, 2'b01, "R4 flag kept");
    rd(4'h2, 0, 32'h04, "R4 status kept");
    acc(1, 4'hC, 2, 32'h0);
    chk(prd_base, 64'hA534_12FC_0000_0000, "R4 base kept");
    repeat (3) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing reads act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule